// File: doc/BRIEF.md
# Power-Controller Operating Mode Sequencer

This block is the digital mode sequencer of an offline power controller. Comparators outside the block turn the analog conditions into flags: three supply bands, feedback in range, optocoupler disable, main-switch overcurrent, input brownout, overpower, input surge and high-voltage input present. The sequencer turns these flags into one of five operating modes. It also gates the switching enable and picks the current for the high-voltage start-up charger. All durations are parameters counted in clock cycles.

A cold power-up goes through a timed ramp-up phase. In that phase the slow (timed) protections are blanked. After that the controller runs in active mode. Each fault leads to its own recovery path: a short stop after overcurrent, a long stop followed by a restart after brownout, and a timed low-consumption hold after overpower. Low supply or a disabled optocoupler moves the controller into low consumption. An input surge blocks switching at once in any mode and releases only after a hold-off period.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode output is 0 (start-up) and `sw_en` is 0. The mode codes are start-up=0, ramp-up=1, active=2, stop=3, low-consumption=4.
- R2: Start-up is left only when `vcc_on_ok` and `fb_ok` are both high. The next mode is ramp-up if the first-power flag is set, and active otherwise. The flag is cleared when ramp-up is left.
- R3: While `vcc_rst_ok` is low, the next mode is start-up and the first-power flag is set again.
- R4: Ramp-up ignores `bo_det` and `op_det`. It moves to active once SS_CYC cycles have passed with `vcc_rst_ok` high while the first-power flag was set.
- R5: From ramp-up or active, a low `vcc_lc_ok` leads to low-consumption with no timed hold. This takes priority over every fault.
- R6: When `oc_trip` is high, `sw_en` is 0 in the same cycle. In ramp-up or active, `oc_trip` leads to stop for OCP_CYC cycles and then to active.
- R7: In active, `bo_det` (alone or together with `op_det`) held continuously for FLT_CYC cycles leads to stop for REC_CYC cycles and then to start-up.
- R8: In active, `op_det` held without `bo_det` for FLT_CYC cycles leads to low-consumption. The mode stays there for REC_CYC cycles and then until `opto_dis` is low, and then goes to start-up.
- R9: In stop, a high `opto_dis` or a low `vcc_lc_ok` leads to low-consumption with no timed hold.
- R10: A high `surge_det` forces `sw_en` to 0 in the same cycle and in the SURGE_REL cycles after it falls. The mode does not change.
- R11: The `chg_sel` codes are off=0, low=1, high=2. In start-up the value is off if `hv_ok` is low, low if `vcc_lc_ok` is low, high if `vcc_on_ok` is low, and off otherwise. In low-consumption the value is high when `hv_ok` is high and `vcc_on_ok` is low, and off otherwise. In every other mode it is off.
- R12: `sw_en` is high only in ramp-up or active, and only when there is no overcurrent and no surge block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_on_ok | input | 1 | Supply above the turn-on level |
| vcc_lc_ok | input | 1 | Supply above the low-consumption level |
| vcc_rst_ok | input | 1 | Supply above the reset level |
| fb_ok | input | 1 | Both feedback pins inside their operating range |
| opto_dis | input | 1 | Optocoupler pin below its disable level |
| oc_trip | input | 1 | Main-switch overcurrent comparator |
| bo_det | input | 1 | Brownout detected |
| op_det | input | 1 | Overpower detected |
| surge_det | input | 1 | Input above the surge level |
| hv_ok | input | 1 | High-voltage input above the charger start level |
| mode | output | 3 | Current operating mode code |
| sw_en | output | 1 | Switching enable for the gate driver |
| chg_sel | output | 2 | Start-up charger current selection |

## Verification
Several decisions can fall in the same cycle. The bench provokes two of them. In the first, an overcurrent trip arrives on the exact cycle in which the brownout filter would expire. It is judged by whether the short stop (overcurrent) or the long stop (brownout) follows. In the second, an overcurrent trip arrives together with a drop of the low-consumption supply flag. Here low-consumption must win. A surge released while the mode changes is also checked against the behavioural model on every cycle.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [2:0] {
    PSQ_START = 3'd0,
    PSQ_RAMP  = 3'd1,
    PSQ_RUN   = 3'd2,
    PSQ_HALT  = 3'd3,
    PSQ_DOZE  = 3'd4
  } psq_mode_e;

  typedef enum logic [1:0] {
    CHG_OFF  = 2'd0,
    CHG_LOW  = 2'd1,
    CHG_HIGH = 2'd2
  } psq_chg_e;

  // Modes in which the power switch may be driven.
  function automatic logic psq_is_switching(input psq_mode_e m);
    return (m == PSQ_RAMP) || (m == PSQ_RUN);
  endfunction

  // Start-up charger current from mode and supply band.
  function automatic psq_chg_e psq_charge_pick(input psq_mode_e m,
                                               input logic hv,
                                               input logic lc,
                                               input logic on);
    psq_chg_e c;
    c = CHG_OFF;
    if (m == PSQ_START) begin
      if (!hv)      c = CHG_OFF;
      else if (!lc) c = CHG_LOW;
      else if (!on) c = CHG_HIGH;
      else          c = CHG_OFF;
    end else if (m == PSQ_DOZE) begin
      if (hv && !on) c = CHG_HIGH;
    end
    return c;
  endfunction

endpackage

// File: rtl/psq_softstart.sv
module psq_softstart #(
  parameter int unsigned SS_CYC = 850000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic armed,
  output logic done
);
  localparam int unsigned W = $clog2(SS_CYC + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (!supply_ok)                cnt <= '0;
    else if (armed && cnt != W'(SS_CYC)) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == W'(SS_CYC));
endmodule

// File: rtl/psq_fault_filter.sv
module psq_fault_filter #(
  parameter int unsigned FLT_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bo,
  input  logic op,
  output logic bo_trip,
  output logic op_trip
);
  localparam int unsigned W = $clog2(FLT_CYC + 1);

  logic [W-1:0] cnt;
  logic held, last;

  assign held = enable && (bo || op);
  assign last = (cnt == W'(FLT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!held) cnt <= '0;
    else if (!last) cnt <= cnt + 1'b1;
  end

  assign bo_trip = held && last && bo;
  assign op_trip = held && last && !bo;
endmodule

// File: rtl/psq_surge_guard.sv
module psq_surge_guard #(
  parameter int unsigned SURGE_REL = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic surge,
  output logic block
);
  localparam int unsigned W = $clog2(SURGE_REL + 1);

  logic [W-1:0] cnt;
  logic         lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= 1'b0;
      cnt <= '0;
    end else if (surge) begin
      lat <= 1'b1;
      cnt <= W'(SURGE_REL - 1);
    end else if (lat) begin
      if (cnt == '0) lat <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign block = surge || lat;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int unsigned SS_CYC    = 850000,
  parameter int unsigned FLT_CYC   = 100000,
  parameter int unsigned OCP_CYC   = 1000,
  parameter int unsigned REC_CYC   = 2500000,
  parameter int unsigned SURGE_REL = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vcc_on_ok,
  input  logic       vcc_lc_ok,
  input  logic       vcc_rst_ok,
  input  logic       fb_ok,
  input  logic       opto_dis,
  input  logic       oc_trip,
  input  logic       bo_det,
  input  logic       op_det,
  input  logic       surge_det,
  input  logic       hv_ok,
  output logic [2:0] mode,
  output logic       sw_en,
  output logic [1:0] chg_sel
);
  import psq_pkg::*;

  localparam int unsigned HOLD_MAX = (REC_CYC > OCP_CYC) ? REC_CYC : OCP_CYC;
  localparam int unsigned HOLD_W   = $clog2(HOLD_MAX + 1);

  psq_mode_e          mode_q, mode_d;
  logic               first_q, first_d;
  logic               cause_bo_q, cause_bo_d;
  logic [HOLD_W-1:0]  hold_q, hold_d;

  // Named internal events (observed by the checker).
  logic ss_done, bo_trip, op_trip, surge_block, run_en;

  assign run_en = (mode_q == PSQ_RUN);

  psq_softstart #(.SS_CYC(SS_CYC)) u_ss (
    .clk(clk), .rst_n(rst_n), .supply_ok(vcc_rst_ok),
    .armed(first_q), .done(ss_done)
  );

  psq_fault_filter #(.FLT_CYC(FLT_CYC)) u_flt (
    .clk(clk), .rst_n(rst_n), .enable(run_en), .bo(bo_det), .op(op_det),
    .bo_trip(bo_trip), .op_trip(op_trip)
  );

  psq_surge_guard #(.SURGE_REL(SURGE_REL)) u_srg (
    .clk(clk), .rst_n(rst_n), .surge(surge_det), .block(surge_block)
  );

  always_comb begin
    mode_d     = mode_q;
    first_d    = first_q;
    cause_bo_d = cause_bo_q;
    hold_d     = hold_q;
    if (!vcc_rst_ok) begin
      mode_d     = PSQ_START;
      first_d    = 1'b1;
      cause_bo_d = 1'b0;
      hold_d     = '0;
    end else begin
      unique case (mode_q)
        PSQ_START: begin
          if (vcc_on_ok && fb_ok) mode_d = first_q ? PSQ_RAMP : PSQ_RUN;
        end
        PSQ_RAMP, PSQ_RUN: begin
          if (!vcc_lc_ok) begin
            mode_d = PSQ_DOZE;
            hold_d = '0;
          end else if (oc_trip) begin
            mode_d     = PSQ_HALT;
            hold_d     = HOLD_W'(OCP_CYC - 1);
            cause_bo_d = 1'b0;
          end else if (bo_trip) begin
            mode_d     = PSQ_HALT;
            hold_d     = HOLD_W'(REC_CYC - 1);
            cause_bo_d = 1'b1;
          end else if (op_trip) begin
            mode_d = PSQ_DOZE;
            hold_d = HOLD_W'(REC_CYC - 1);
          end else if (mode_q == PSQ_RAMP && ss_done) begin
            mode_d = PSQ_RUN;
          end
          if (mode_q == PSQ_RAMP && mode_d != PSQ_RAMP) first_d = 1'b0;
        end
        PSQ_HALT: begin
          if (opto_dis || !vcc_lc_ok) begin
            mode_d = PSQ_DOZE;
            hold_d = '0;
          end else if (hold_q == '0) begin
            mode_d = cause_bo_q ? PSQ_START : PSQ_RUN;
          end else begin
            hold_d = hold_q - 1'b1;
          end
        end
        PSQ_DOZE: begin
          if (hold_q != '0)   hold_d = hold_q - 1'b1;
          else if (!opto_dis) mode_d = PSQ_START;
        end
        default: mode_d = PSQ_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= PSQ_START;
      first_q    <= 1'b1;
      cause_bo_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      mode_q     <= mode_d;
      first_q    <= first_d;
      cause_bo_q <= cause_bo_d;
      hold_q     <= hold_d;
    end
  end

  assign mode    = mode_q;
  assign sw_en   = psq_is_switching(mode_q) && !oc_trip && !surge_block;
  assign chg_sel = psq_charge_pick(mode_q, hv_ok, vcc_lc_ok, vcc_on_ok);
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vcc_on_ok,
  input logic       vcc_lc_ok,
  input logic       vcc_rst_ok,
  input logic       fb_ok,
  input logic       oc_trip,
  input logic       surge_det,
  input logic [2:0] mode,
  input logic       sw_en,
  input logic [1:0] chg_sel,
  input logic       bo_trip,
  input logic       op_trip
);
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);

  a_r12_sw_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> (mode == 3'd1 || mode == 3'd2));

  a_r6_oc_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |-> !sw_en);

  a_r10_surge_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    surge_det |-> !sw_en);

  a_r3_reset_level: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_rst_ok |=> mode == 3'd0);

  a_r11_charger_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 || mode == 3'd2 || mode == 3'd3) |-> chg_sel == 2'd0);

  a_r2_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && vcc_rst_ok && !(vcc_on_ok && fb_ok)) |=> mode == 3'd0);

  a_r4_ramp_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> (!bo_trip && !op_trip));

  a_r7_bo_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_trip && vcc_rst_ok && vcc_lc_ok && !oc_trip) |=> mode == 3'd3);

  a_r8_op_to_doze: assert property (@(posedge clk) disable iff (!rst_n)
    (op_trip && vcc_rst_ok && vcc_lc_ok && !oc_trip) |=> mode == 3'd4);

  a_r5_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd1 || mode == 3'd2) && vcc_rst_ok && !vcc_lc_ok) |=> mode == 3'd4);
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .vcc_on_ok(vcc_on_ok), .vcc_lc_ok(vcc_lc_ok),
  .vcc_rst_ok(vcc_rst_ok), .fb_ok(fb_ok), .oc_trip(oc_trip),
  .surge_det(surge_det), .mode(mode), .sw_en(sw_en), .chg_sel(chg_sel),
  .bo_trip(bo_trip), .op_trip(op_trip)
);

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SS  = 40;
  localparam int FLT = 8;
  localparam int OCP = 5;
  localparam int REC = 20;
  localparam int REL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on = 0, lc = 0, rok = 0, fb = 0, opto = 0, oc = 0, bo = 0, op = 0, surge = 0, hv = 0;
  logic [2:0] mode;
  logic       sw_en;
  logic [1:0] chg_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_seq #(.SS_CYC(SS), .FLT_CYC(FLT), .OCP_CYC(OCP), .REC_CYC(REC), .SURGE_REL(REL)) u0 (
    .clk(clk), .rst_n(rst_n), .vcc_on_ok(on), .vcc_lc_ok(lc), .vcc_rst_ok(rok),
    .fb_ok(fb), .opto_dis(opto), .oc_trip(oc), .bo_det(bo), .op_det(op),
    .surge_det(surge), .hv_ok(hv), .mode(mode), .sw_en(sw_en), .chg_sel(chg_sel)
  );

  // Behavioural reference state
  int m_mode = 0, m_first = 1, m_ss = 0, m_flt = 0, m_hold = 0, m_cause = 0;
  int m_lat = 0, m_rel = 0;
  int vectors = 0, fails = 0;
  bit finished = 0;

  function automatic int exp_chg();
    if (m_mode == 0) begin
      if (!hv) return 0;
      if (!lc) return 1;
      if (!on) return 2;
      return 0;
    end
    if (m_mode == 4) return (hv && !on) ? 2 : 0;
    return 0;
  endfunction

  function automatic int exp_sw();
    if (m_mode != 1 && m_mode != 2) return 0;
    if (oc || surge || m_lat != 0) return 0;
    return 1;
  endfunction

  task automatic model_step();
    int nm, nh, nc, nf;
    bit held, trip;
    held = (m_mode == 2) && (bo || op);
    trip = held && (m_flt == FLT - 1);
    nm = m_mode; nh = m_hold; nc = m_cause; nf = m_first;
    if (!rok) begin
      nm = 0; nf = 1; nh = 0; nc = 0;
    end else if (m_mode == 0) begin
      if (on && fb) nm = (m_first != 0) ? 1 : 2;
    end else if (m_mode == 1 || m_mode == 2) begin
      if (!lc)              begin nm = 4; nh = 0; end
      else if (oc)          begin nm = 3; nh = OCP - 1; nc = 0; end
      else if (trip && bo)  begin nm = 3; nh = REC - 1; nc = 1; end
      else if (trip)        begin nm = 4; nh = REC - 1; end
      else if (m_mode == 1 && m_ss == SS) nm = 2;
      if (m_mode == 1 && nm != 1) nf = 0;
    end else if (m_mode == 3) begin
      if (opto || !lc)      begin nm = 4; nh = 0; end
      else if (m_hold == 0) nm = (m_cause != 0) ? 0 : 2;
      else                  nh = m_hold - 1;
    end else begin
      if (m_hold != 0)      nh = m_hold - 1;
      else if (!opto)       nm = 0;
    end
    if (!rok) m_ss = 0;
    else if (m_first != 0 && m_ss != SS) m_ss++;
    if (!held) m_flt = 0;
    else if (m_flt != FLT - 1) m_flt++;
    if (surge) begin m_lat = 1; m_rel = REL - 1; end
    else if (m_lat != 0) begin
      if (m_rel == 0) m_lat = 0; else m_rel--;
    end
    m_mode = nm; m_hold = nh; m_cause = nc; m_first = nf;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vectors++;
      if (int'(mode) != m_mode || int'(sw_en) != exp_sw() || int'(chg_sel) != exp_chg()) begin
        fails++;
        $display("FAIL %s t=%0t mode/sw/chg actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 tag, $time, mode, sw_en, chg_sel, m_mode, exp_sw(), exp_chg());
      end
      @(posedge clk);
      if (rst_n) model_step();
      #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run(2, "R1 reset state");
    hv = 1; rok = 1;                 run(3, "R11 low charge below lc level");
    lc = 1;                          run(3, "R11 high charge");
    on = 1;                          run(3, "R2 start holds without feedback");
    fb = 1;                          run(2, "R2 first power to ramp");
    bo = 1; op = 1;                  run(15, "R4 ramp ignores timed faults");
    bo = 0; op = 0;                  run(30, "R4 ramp ends in active");
    oc = 1;                          run(1, "R6 overcurrent gate off");
    oc = 0;                          run(12, "R6 short stop then active");
    bo = 1;                          run(10, "R7 brownout filter");
    bo = 0;                          run(30, "R7 long stop then restart");
    op = 1;                          run(10, "R8 overpower filter");
    op = 0; opto = 1;                run(30, "R8 low-consumption hold");
    opto = 0;                        run(6, "R8 reload to active");
    lc = 0;                          run(4, "R5 supply low to low-consumption");
    on = 0;                          run(3, "R11 charger on in low-consumption");
    on = 1; lc = 1;                  run(5, "R5 recover");
    oc = 1;                          run(1, "R6 trip");
    oc = 0;                          run(2, "R9 in stop");
    opto = 1;                        run(4, "R9 opto disable in stop");
    opto = 0;                        run(5, "R9 recover");
    oc = 1;                          run(1, "R6 trip");
    oc = 0; lc = 0;                  run(3, "R9 low supply in stop");
    lc = 1;                          run(5, "R9 recover");
    surge = 1;                       run(3, "R10 surge blocks");
    surge = 0;                       run(8, "R10 surge release");
    bo = 1;                          run(7, "R7 filter near expiry");
    oc = 1;                          run(1, "R6 overcurrent beats brownout");
    oc = 0; bo = 0;                  run(10, "R6 short stop after tie");
    oc = 1; lc = 0;                  run(1, "R5 low supply beats overcurrent");
    oc = 0;                          run(3, "R5 in low-consumption");
    lc = 1; surge = 1;               run(2, "R10 surge while leaving");
    surge = 0;                       run(8, "R10 release in active");
    rok = 0;                         run(3, "R3 below reset level");
    rok = 1;                         run(5, "R3 first power again");
    run(45, "R12 ramp to active again");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    finished = 1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule